// File: doc/BRIEF.md
# Stream-to-Memory Receive Channel

This block is the receiving half of a DMA engine. Software writes the base byte address and then a transfer length, counted in 32-bit words. The length write arms the channel and raises TREADY. The channel then takes AXI4-Stream beats and adds the number of valid bytes in each accepted beat to a running count. Each accepted word that has at least one valid byte goes out on a simple memory-write port. That port carries an address, data and a byte strobe, and the addresses are consecutive words starting at the base.

The end of a transfer depends on where TLAST falls relative to the programmed length:

- **TLAST on the beat that reaches the length:** the channel returns to Idle and raises the completion interrupt.
- **TLAST before the length is reached:** the transfer ends early in the same way. The received byte count stays readable.
- **Length reached without TLAST on that beat:** this is an internal error. The channel halts and raises the error interrupt.
- **Stream stops short and gives no TLAST:** the channel waits indefinitely, neither Idle nor Halted, until more beats fill the length.
- **Beats whose byte-keep bits are all zero:** these carry no data and are ignored.

Top module: `s2mm_rx_chan`

## Requirements
- R1: After reset the status reads 0x01 (Idle only). TREADY, both interrupts and the memory write enable are low, and the received byte count reads 0.
- R2: Register selects are 0 for length (words), 1 for status, 2 for received bytes and 3 for base address. A nonzero length write while the channel is not running does three things: it clears the status to 0x00, zeroes the count and raises TREADY on the next cycle. A zero length is ignored. Length and base writes while running are ignored.
- R3: While the channel is not armed, TREADY is low and offered beats cause no memory write and no count change.
- R4: Each accepted beat adds the number of set TKEEP bits to the received byte count, which is read at select 2.
- R5: A beat with TKEEP all zero changes neither the count nor the status, and causes no memory write.
- R6: Status bits are bit0 Idle, bit1 Halted, bit2 internal error, bit3 completion interrupt and bit4 error interrupt. A beat carrying TLAST whose bytes bring the count exactly to four times the length gives status 0x09 and drops TREADY.
- R7: A beat that brings the count to the length or beyond without TLAST gives status 0x16. It raises the error interrupt and drops TREADY.
- R8: A stream that stops below the length without TLAST keeps the status at 0x00 with TREADY high, for any idle time. Further beats that fill the length complete the transfer.
- R9: TLAST on a beat that leaves the count below the length ends the transfer with status 0x09. The count read back is the bytes actually received.
- R10: One cycle after an accepted beat with any TKEEP bit set, the memory port asserts a write. The address is base + 4*k for the k-th such word since arming, and the port carries the beat's data with TKEEP as the strobe.
- R11: Writing status with ones clears bits 2, 3 and 4, and writing zeros changes nothing. Halted is left only by arming again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| s_axis_tdata | input | 32 | Stream data word |
| s_axis_tkeep | input | 4 | Byte-valid bits |
| s_axis_tlast | input | 1 | End-of-packet marker |
| s_axis_tvalid | input | 1 | Beat offered |
| s_axis_tready | output | 1 | Channel armed and accepting |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_strb | output | 4 | Memory byte strobe |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench builds the channel with an 8-bit length field and a 16-bit address. The narrow address field checks that base and word offset combine within the address width. The short lengths make exact-fill, early-TLAST, overrun and partial-keep transfers cheap to exercise, each in a few beats. The hung-and-resume case and the ignored length write while running are both reached within tens of cycles.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;
  localparam int WORD_W = 32;
  localparam int KEEP_W = WORD_W / 8;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_HALT = 2'd2
  } ch_state_t;

  localparam logic [1:0] SEL_LEN  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_RCV  = 2'd2;
  localparam logic [1:0] SEL_BASE = 2'd3;

  localparam int ST_IDLE = 0;
  localparam int ST_HALT = 1;
  localparam int ST_IERR = 2;
  localparam int ST_DONE = 3;
  localparam int ST_EIRQ = 4;
endpackage

// File: rtl/s2mm_len_track.sv
module s2mm_len_track
  import s2mm_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int CNT_W = LEN_W + 2,
  localparam int POP_W = $clog2(KEEP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              beat,
  input  logic [KEEP_W-1:0] keep,
  input  logic              last,
  input  logic [CNT_W-1:0]  target,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [LEN_W-1:0]  word_idx,
  output logic              ev_done,
  output logic              ev_err
);
  logic [POP_W-1:0] pop;
  logic             keep_any;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   tgt_x;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic [LEN_W-1:0] word_d;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] word_q;

  always_comb begin
    pop = '0;
    for (int i = 0; i < KEEP_W; i++) pop = pop + POP_W'(keep[i]);
  end

  assign keep_any = |keep;
  assign sum      = {1'b0, cnt_q} + (CNT_W + 1)'(pop);
  assign tgt_x    = {1'b0, target};
  assign ev_done  = beat && keep_any && last && (sum <= tgt_x);
  assign ev_err   = beat && keep_any && (last ? (sum > tgt_x) : (sum >= tgt_x));

  always_comb begin
    cnt_en = clr || (beat && keep_any);
    cnt_d  = clr ? '0 : sum[CNT_W-1:0];
    word_d = clr ? '0 : word_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      word_q <= word_d;
    end
  end

  assign byte_cnt = cnt_q;
  assign word_idx = word_q;

  // R5
  keep_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && (keep == '0) && !clr) |=> $stable(byte_cnt));
endmodule

// File: rtl/s2mm_ctrl_regs.sv
module s2mm_ctrl_regs
  import s2mm_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  localparam int CNT_W = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic [CNT_W-1:0]  byte_cnt,
  output logic              arm,
  output logic              busy,
  output logic [CNT_W-1:0]  target,
  output logic [ADDR_W-1:0] base,
  output logic              irq_done,
  output logic              irq_err
);
  ch_state_t         state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              ierr_q, ierr_d;
  logic              done_q, done_d;
  logic              eirq_q, eirq_d;
  logic              cfg_open, base_en, len_en, st_en;
  logic [4:0]        stat_word;

  assign cfg_open = (state_q != CH_RUN);
  assign arm      = cfg_open && reg_wr_en && (reg_sel == SEL_LEN) &&
                    (reg_wdata[LEN_W-1:0] != '0);
  assign base_en  = cfg_open && reg_wr_en && (reg_sel == SEL_BASE);
  assign len_en   = arm;

  always_comb begin
    state_d = state_q;
    len_d   = reg_wdata[LEN_W-1:0];
    base_d  = reg_wdata[ADDR_W-1:0];
    ierr_d  = ierr_q;
    done_d  = done_q;
    eirq_d  = eirq_q;
    if (reg_wr_en && (reg_sel == SEL_STAT)) begin
      if (reg_wdata[ST_IERR]) ierr_d = 1'b0;
      if (reg_wdata[ST_DONE]) done_d = 1'b0;
      if (reg_wdata[ST_EIRQ]) eirq_d = 1'b0;
    end
    if (arm) begin
      state_d = CH_RUN;
      ierr_d  = 1'b0;
      done_d  = 1'b0;
      eirq_d  = 1'b0;
    end else if (state_q == CH_RUN) begin
      if (ev_err) begin
        state_d = CH_HALT;
        ierr_d  = 1'b1;
        eirq_d  = 1'b1;
      end else if (ev_done) begin
        state_d = CH_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  assign st_en = (state_d != state_q) || (ierr_d != ierr_q) ||
                 (done_d != done_q) || (eirq_d != eirq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      ierr_q  <= 1'b0;
      done_q  <= 1'b0;
      eirq_q  <= 1'b0;
    end else if (st_en) begin
      state_q <= state_d;
      ierr_q  <= ierr_d;
      done_q  <= done_d;
      eirq_q  <= eirq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign stat_word = {eirq_q, done_q, ierr_q, (state_q == CH_HALT), (state_q == CH_IDLE)};

  always_comb begin
    case (reg_sel)
      SEL_LEN:  reg_rdata = 32'(len_q);
      SEL_STAT: reg_rdata = 32'(stat_word);
      SEL_RCV:  reg_rdata = 32'(byte_cnt);
      default:  reg_rdata = 32'(base_q);
    endcase
  end

  assign busy     = (state_q == CH_RUN);
  assign target   = {len_q, 2'b00};
  assign base     = base_q;
  assign irq_done = done_q;
  assign irq_err  = eirq_q;

  // R7
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_err) |=> (state_q == CH_HALT) && irq_err && ierr_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_done && !ev_err) |=> (state_q == CH_IDLE) && irq_done);
endmodule

// File: rtl/s2mm_mem_wr.sv
module s2mm_mem_wr
  import s2mm_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [KEEP_W-1:0] keep,
  input  logic [WORD_W-1:0] data,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  word_idx,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [KEEP_W-1:0] mem_strb
);
  logic              wr_go;
  logic [ADDR_W-1:0] addr_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [KEEP_W-1:0] strb_q;

  assign wr_go  = beat && (|keep);
  assign addr_d = base + ADDR_W'({word_idx, 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= wr_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
    end else if (wr_go) begin
      addr_q <= addr_d;
      data_q <= data;
      strb_q <= keep;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_strb  = strb_q;

  // R10
  mem_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));
endmodule

// File: rtl/s2mm_rx_chan.sv
module s2mm_rx_chan
  import s2mm_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  localparam int CNT_W = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       s_axis_tdata,
  input  logic [3:0]        s_axis_tkeep,
  input  logic              s_axis_tlast,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_strb,
  output logic              irq_done,
  output logic              irq_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              arm, busy, beat, ev_done, ev_err;
  logic [CNT_W-1:0]  target, byte_cnt;
  logic [LEN_W-1:0]  word_idx;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign s_axis_tready = busy;
  assign beat          = s_axis_tvalid && busy;

  s2mm_ctrl_regs #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_done(ev_done), .ev_err(ev_err),
    .byte_cnt(byte_cnt), .arm(arm), .busy(busy), .target(target),
    .base(base), .irq_done(irq_done), .irq_err(irq_err)
  );

  s2mm_len_track #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .clr(arm), .beat(beat),
    .keep(s_axis_tkeep), .last(s_axis_tlast), .target(target),
    .byte_cnt(byte_cnt), .word_idx(word_idx),
    .ev_done(ev_done), .ev_err(ev_err)
  );

  s2mm_mem_wr #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_int_n), .beat(beat), .keep(s_axis_tkeep),
    .data(s_axis_tdata), .base(base), .word_idx(word_idx),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb)
  );

  // R2
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    arm |=> (byte_cnt == '0) && !irq_done && !irq_err && s_axis_tready);
endmodule

// File: tb/test_s2mm_rx_chan.sv
module test_s2mm_rx_chan;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LEN_W  = 8;
  localparam int  ADDR_W = 16;
  localparam int  NV     = 5;
  localparam logic [7:0]  V_LEN   [NV] = '{8'd4, 8'd4, 8'd3, 8'd2, 8'd2};
  localparam int          V_BEATS [NV] = '{4, 2, 3, 4, 2};
  localparam logic [3:0]  V_KEEP  [NV] = '{4'hF, 4'hF, 4'hF, 4'h3, 4'h8};
  localparam logic        V_LAST  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_STAT  [NV] = '{32'h09, 32'h09, 32'h16, 32'h09, 32'h09};
  localparam logic [31:0] V_BYTES [NV] = '{32'd16, 32'd8, 32'd12, 32'd8, 32'd2};

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr_en;
  logic [1:0] reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] s_axis_tdata;
  logic [3:0] s_axis_tkeep;
  logic s_axis_tlast, s_axis_tvalid, s_axis_tready;
  logic mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_strb;
  logic irq_done, irq_err;

  int checks = 0;
  int errors = 0;
  int widx = 0;
  logic [ADDR_W-1:0] cur_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  s2mm_rx_chan #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_s2mm_rx_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_axis_tdata(s_axis_tdata), .s_axis_tkeep(s_axis_tkeep),
    .s_axis_tlast(s_axis_tlast), .s_axis_tvalid(s_axis_tvalid),
    .s_axis_tready(s_axis_tready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_strb(mem_strb),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic arm_ch(input logic [ADDR_W-1:0] b, input logic [31:0] len);
    wr(2'd3, 32'(b));
    wr(2'd0, len);
    cur_base = b;
    widx = 0;
  endtask

  task automatic send(input logic [31:0] d, input logic [3:0] k, input logic l, input string tag);
    logic rdy;
    rdy = s_axis_tready;
    s_axis_tdata = d; s_axis_tkeep = k; s_axis_tlast = l; s_axis_tvalid = 1'b1;
    @(negedge clk);
    s_axis_tvalid = 1'b0; s_axis_tlast = 1'b0;
    if (rdy && (k != 4'h0)) begin
      chk({tag, " mem_we"}, 32'(mem_we), 32'd1);
      chk({tag, " mem_addr"}, 32'(mem_addr), 32'(cur_base + ADDR_W'(4 * widx)));
      chk({tag, " mem_wdata"}, mem_wdata, d);
      chk({tag, " mem_strb"}, 32'(mem_strb), 32'(k));
      widx++;
    end else begin
      chk({tag, " no mem write"}, 32'(mem_we), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    s_axis_tdata = '0; s_axis_tkeep = '0; s_axis_tlast = 1'b0; s_axis_tvalid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 32'h01);
    rd(2'd2, v); chk("R1 bytes", v, 32'd0);
    chk("R1 tready", 32'(s_axis_tready), 32'd0);
    chk("R1 irqs", 32'({irq_done, irq_err}), 32'd0);
    chk("R1 mem_we", 32'(mem_we), 32'd0);

    // R3 beats offered before arming
    send(32'hDEAD0001, 4'hF, 1'b1, "R3");
    rd(2'd2, v); chk("R3 bytes", v, 32'd0);
    rd(2'd1, v); chk("R3 status", v, 32'h01);

    // R2 zero length ignored
    wr(2'd0, 32'd0);
    rd(2'd1, v); chk("R2 zero len status", v, 32'h01);
    chk("R2 zero len tready", 32'(s_axis_tready), 32'd0);

    // Vector table: R4 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      arm_ch(ADDR_W'(16'h0100 + 16'(i) * 16'h0040), 32'(V_LEN[i]));
      rd(2'd1, v); chk("R2 armed status", v, 32'h00);
      chk("R2 armed tready", 32'(s_axis_tready), 32'd1);
      for (int b = 0; b < V_BEATS[i]; b++)
        send(32'hA0000000 + 32'(i * 16 + b), V_KEEP[i],
             (b == V_BEATS[i] - 1) && V_LAST[i], "R10");
      rd(2'd1, v); chk("R6/R7/R9 status", v, V_STAT[i]);
      rd(2'd2, v); chk("R4/R9 bytes", v, V_BYTES[i]);
      chk("R6/R7 tready low", 32'(s_axis_tready), 32'd0);
      chk("R7 irq_err", 32'(irq_err), 32'(V_STAT[i][4]));
    end

    // R11 write-one-to-clear
    wr(2'd1, 32'h00);
    rd(2'd1, v); chk("R11 zero write", v, 32'h09);
    wr(2'd1, 32'h08);
    rd(2'd1, v); chk("R11 clear done", v, 32'h01);
    chk("R11 irq_done low", 32'(irq_done), 32'd0);

    arm_ch(16'h0300, 32'd1);
    send(32'h11112222, 4'hF, 1'b0, "R10");
    rd(2'd1, v); chk("R7 overrun status", v, 32'h16);
    wr(2'd1, 32'h14);
    rd(2'd1, v); chk("R11 halted stays", v, 32'h02);
    chk("R11 irq_err low", 32'(irq_err), 32'd0);
    chk("R7 halted tready", 32'(s_axis_tready), 32'd0);

    // R5 keep-zero beats, R8 short stream and resume
    arm_ch(16'h0400, 32'd4);
    for (int b = 0; b < 3; b++) send(32'h0BAD0000, 4'h0, 1'b1, "R5");
    rd(2'd2, v); chk("R5 bytes", v, 32'd0);
    rd(2'd1, v); chk("R5 status", v, 32'h00);
    for (int b = 0; b < 3; b++) send(32'h50000000 + 32'(b), 4'hF, 1'b0, "R10");
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R8 hung status", v, 32'h00);
    rd(2'd2, v); chk("R8 hung bytes", v, 32'd12);
    chk("R8 hung tready", 32'(s_axis_tready), 32'd1);
    wr(2'd0, 32'd9);
    rd(2'd0, v); chk("R2 busy length write", v, 32'd4);
    send(32'h50000003, 4'hF, 1'b1, "R10");
    rd(2'd1, v); chk("R8 resumed status", v, 32'h09);
    rd(2'd2, v); chk("R8 resumed bytes", v, 32'd16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule